// File: doc/BRIEF.md
# Dual-Output PWM Generator with Buffered Updates

This block produces two pulse-width modulated outputs, A and B, from one shared time-base counter. A prescaler divides the system clock into counter ticks. On each tick the counter either ramps up and wraps, or ramps up and back down, depending on the selected mode. Each output is set when the counter reaches zero and cleared when the counter meets that output's own compare value while the counter is rising.

Software uses a simple write port to set the period, the two compare values and the control word. Period and compare writes go into holding registers. The holding values are copied into the working registers only when the counter reaches zero, so a running period is never disturbed. Control writes (mode and prescaler) take effect at once.

Top module: `pwm_pair_gen`

## Requirements
- R1: In up-count mode (control bit 0 = 0), the counter steps 0, 1, ... P and then returns to 0, so one period lasts (P+1) ticks.
- R2: In up-down mode (control bit 0 = 1), the counter steps 0, 1, ... P, P-1, ... 1 and then returns to 0, so one period lasts 2·P ticks.
- R3: One tick lasts (H+1)·(K+1) clock cycles. H is taken from control bits [DIV_W:1] and K from control bits [2·DIV_W:DIV_W+1]. The write addresses are: 0 = period, 1 = compare A, 2 = compare B, 3 = control.
- R4: Output A goes high at the tick on which the counter becomes 0. It goes low at the tick on which the counter rises to compare A. For 1 ≤ C ≤ P in up-count mode, it is therefore high for C ticks of every period.
- R5: Output B follows the same rule as output A, using compare B. Its level does not depend on compare A.
- R6: A compare write does not change the pulse already in progress. The new value first governs the pulse that starts at the next counter zero.
- R7: A period write does not change the length of the period in progress. The new length applies from the next counter zero.
- R8: After reset, the counter is 0 and both outputs are low. The period, both compare values and both prescaler fields are 0, and the mode is up-count.
- R9: A compare value of 0 keeps that output low in every period, because a clear wins over a set that occurs on the same tick.
- R10: A compare value greater than the period never matches, so that output stays high for the whole period.
- R11: In up-down mode, a match while the counter is falling has no effect. For 1 ≤ C ≤ P, the output is high for C ticks out of 2·P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 period, 1 compare A, 2 compare B, 3 control |
| wr_data | input | W | Write data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| cnt | output | W | Current time-base count |
| cnt_up | output | 1 | Counter direction, 1 while rising |

## Verification
On every cycle, the assertions check the following:
- the counter never exceeds the working period;
- the counter moves only on a prescaler tick;
- the working period and compare registers change only when the counter returns to zero;
- each output rises only at zero and falls only where the counter equals its compare value.

Some behaviour can only be shown by the bench scenarios. These are the pulse widths and period lengths across modes, prescaler settings and compare values, including the zero and above-period corner cases. They also include the fact that a mid-period write leaves the current pulse untouched and shows up in the next one.

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen #(
  parameter int W     = 16,
  parameter int DIV_W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic [W-1:0] cnt,
  output logic         cnt_up
);
  localparam int PW = 2*DIV_W + 1;

  logic [W-1:0]     prd_sh, prd_act, cmpa_sh, cmpa_act, cmpb_sh, cmpb_act;
  logic             mode_ud;
  logic [DIV_W-1:0] hs_div, ck_div;
  logic [PW-1:0]    pre;

  wire [PW-1:0] hs_x   = PW'(hs_div) + PW'(1);
  wire [PW-1:0] ck_x   = PW'(ck_div) + PW'(1);
  wire [PW-1:0] div_m1 = PW'(hs_x * ck_x) - PW'(1);
  wire          tick   = (pre >= div_m1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prd_sh  <= '0;
      cmpa_sh <= '0;
      cmpb_sh <= '0;
      mode_ud <= 1'b0;
      hs_div  <= '0;
      ck_div  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: prd_sh  <= wr_data;
        2'd1: cmpa_sh <= wr_data;
        2'd2: cmpb_sh <= wr_data;
        default: begin
          mode_ud <= wr_data[0];
          hs_div  <= wr_data[DIV_W:1];
          ck_div  <= wr_data[2*DIV_W:DIV_W+1];
        end
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + PW'(1);

  logic [W-1:0] nxt_cnt;
  logic         nxt_up, stepped_up;

  always_comb begin
    nxt_cnt    = cnt;
    nxt_up     = cnt_up;
    stepped_up = 1'b1;
    if (!mode_ud) begin
      nxt_up  = 1'b1;
      nxt_cnt = (cnt >= prd_act) ? '0 : cnt + W'(1);
    end else if (cnt_up || cnt == '0) begin
      if (cnt >= prd_act) begin
        if (cnt == '0) begin
          nxt_cnt = '0;
          nxt_up  = 1'b1;
        end else begin
          nxt_cnt    = cnt - W'(1);
          nxt_up     = 1'b0;
          stepped_up = 1'b0;
        end
      end else begin
        nxt_cnt = cnt + W'(1);
        nxt_up  = 1'b1;
      end
    end else begin
      nxt_cnt    = cnt - W'(1);
      nxt_up     = (cnt == W'(1));
      stepped_up = 1'b0;
    end
  end

  wire          zero   = (nxt_cnt == '0);
  wire          up_evt = stepped_up | zero;
  wire [W-1:0]  ca_nxt = zero ? cmpa_sh : cmpa_act;
  wire [W-1:0]  cb_nxt = zero ? cmpb_sh : cmpb_act;
  wire          hit_a  = up_evt & (nxt_cnt == ca_nxt);
  wire          hit_b  = up_evt & (nxt_cnt == cb_nxt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt      <= '0;
      cnt_up   <= 1'b1;
      prd_act  <= '0;
      cmpa_act <= '0;
      cmpb_act <= '0;
      pwm_a    <= 1'b0;
      pwm_b    <= 1'b0;
    end else if (tick) begin
      cnt    <= nxt_cnt;
      cnt_up <= nxt_up;
      if (zero) begin
        prd_act  <= prd_sh;
        cmpa_act <= cmpa_sh;
        cmpb_act <= cmpb_sh;
      end
      pwm_a <= hit_a ? 1'b0 : (zero ? 1'b1 : pwm_a);
      pwm_b <= hit_b ? 1'b0 : (zero ? 1'b1 : pwm_b);
    end
endmodule

module pwm_pair_gen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] cnt,
  input logic [W-1:0] prd_act,
  input logic [W-1:0] cmpa_act,
  input logic [W-1:0] cmpb_act,
  input logic         pwm_a,
  input logic         pwm_b
);
  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= prd_act);

  a_r3_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> $past(tick));

  a_r6_cmpa_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmpa_act) |-> cnt == '0);

  a_r6_cmpb_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmpb_act) |-> cnt == '0);

  a_r7_prd_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prd_act) |-> cnt == '0);

  a_r4_a_rises_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_a) |-> cnt == '0);

  a_r4_a_falls_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_a) |-> cnt == cmpa_act);

  a_r5_b_rises_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_b) |-> cnt == '0);

  a_r5_b_falls_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_b) |-> cnt == cmpb_act);
endmodule

bind pwm_pair_gen pwm_pair_gen_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .prd_act(prd_act),
  .cmpa_act(cmpa_act), .cmpb_act(cmpb_act), .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/pwm_pair_gen_tb_top.sv
module pwm_pair_gen_tb_top;
  localparam int W = 16;
  localparam int DIV_W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         pwm_a, pwm_b, cnt_up;
  logic [W-1:0] cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pwm_pair_gen #(.W(W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .cnt(cnt), .cnt_up(cnt_up)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int hi_ticks(input bit ud, input int p, input int c);
    if (c == 0) return 0;
    if (c > p)  return ud ? 2*p : p+1;
    return c;
  endfunction

  task automatic measure(input int n, input bit mid, input logic [1:0] ma, input int md,
                         output int ha, output int hb, output bit pok);
    int prevc;
    ha = 0; hb = 0;
    do begin
      prevc = int'(cnt);
      @(negedge clk);
    end while (!(prevc != 0 && cnt == '0));
    for (int i = 0; i < n; i++) begin
      ha += int'(pwm_a);
      hb += int'(pwm_b);
      if (mid && i == 1) begin wr_en = 1'b1; wr_addr = ma; wr_data = W'(md); end
      if (mid && i == 2) wr_en = 1'b0;
      prevc = int'(cnt);
      @(negedge clk);
    end
    pok = (cnt == '0) && (prevc != 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int ha, hb, n, div, ea, eb;
    bit pok;
    string tag;
    int hs_t[3] = '{0, 2, 1};
    int ck_t[3] = '{0, 0, 1};
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(cnt == '0, "R8 cnt", int'(cnt), 0);
    chk(pwm_a == 1'b0, "R8 pwm_a", int'(pwm_a), 0);
    chk(pwm_b == 1'b0, "R8 pwm_b", int'(pwm_b), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cnt == '0 && !pwm_a && !pwm_b, "R8 idle after reset", int'(cnt), 0);

    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 3; d++)
        for (int p = 2; p <= 5; p++)
          for (int c = 0; c <= p + 1; c++) begin
            div = (hs_t[d] + 1) * (ck_t[d] + 1);
            wr(2'd3, m | (hs_t[d] << 1) | (ck_t[d] << (DIV_W + 1)));
            wr(2'd0, p);
            wr(2'd1, c);
            wr(2'd2, p + 1 - c);
            n  = (m ? 2*p : p+1) * div;
            ea = hi_ticks(m[0], p, c) * div;
            eb = hi_ticks(m[0], p, p + 1 - c) * div;
            measure(n, 1'b0, 2'd0, 0, ha, hb, pok);
            tag = (c == 0) ? "R9" : (c > p) ? "R10" : (m == 1) ? "R11" : "R4";
            chk(ha == ea, $sformatf("%s A m%0d d%0d p%0d c%0d", tag, m, div, p, c), ha, ea);
            chk(hb == eb, $sformatf("R5 B m%0d d%0d p%0d c%0d", m, div, p, c), hb, eb);
            chk(pok, $sformatf("%s period m%0d d%0d p%0d (R3)", m ? "R2" : "R1", m, div, p),
                int'(pok), 1);
          end

    // R6 compare shadow: write in mid-period, old pulse kept, next pulse new
    wr(2'd3, 0);
    wr(2'd0, 7);
    wr(2'd1, 3);
    wr(2'd2, 5);
    measure(8, 1'b0, 2'd0, 0, ha, hb, pok);
    chk(ha == 3, "R6 baseline A", ha, 3);
    measure(8, 1'b1, 2'd1, 6, ha, hb, pok);
    chk(ha == 3, "R6 current pulse unchanged", ha, 3);
    chk(hb == 5, "R5 B untouched by A write", hb, 5);
    measure(8, 1'b0, 2'd0, 0, ha, hb, pok);
    chk(ha == 6, "R6 next pulse uses new compare", ha, 6);

    // R7 period shadow
    measure(8, 1'b1, 2'd0, 4, ha, hb, pok);
    chk(pok, "R7 current period kept at 8", int'(pok), 1);
    measure(5, 1'b0, 2'd0, 0, ha, hb, pok);
    chk(pok, "R7 new period of 5", int'(pok), 1);
    chk(ha == 5, "R10 A above new period", ha, 5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule